// File: doc/BRIEF.md
# Peripheral Power and Clock Gating Controller

This block decides, for a single peripheral, whether that peripheral receives supply power and whether it receives a clock. Three gating enables are provided, one per operating mode (run, sleep, deep-sleep). The current mode code picks one of them. When the picked enable is low, a software-held power-control bit settles whether the peripheral is kept powered but idle, or switched fully off.

Power and clock are gated on their own. A powered but unclocked peripheral keeps its state. A fully off peripheral loses it. For that reason the block raises a fixed-length peripheral reset whenever power comes back after a full-off period. The clock stays gated until that pulse has ended.

All decisions are taken on an always-on reference clock, and every output comes from a register. The power-control bit lives in a 32-bit register with a plain write-enable interface and a read-back port.

Top module: `pcg_ctrl`

## Requirements
- R1: The mode code picks one gating enable: 2'b00 picks `gate_run`, 2'b01 picks `gate_sleep`, and both 2'b10 and 2'b11 pick `gate_deep`. The enables that are not picked have no effect on the outputs.
- R2: While the picked enable is 1 (and no peripheral reset is in progress), `pwr_en` and `clk_en` are both 1, whatever the power-control bit holds.
- R3: While the picked enable is 0 and the power-control bit is 1, `pwr_en` is 1 and `clk_en` is 0.
- R4: While the picked enable is 0 and the power-control bit is 0, `pwr_en`, `clk_en` and `periph_rst` are all 0, and the peripheral state is treated as lost.
- R5: Power can come back after the fully off state in two ways: the picked enable becoming 1, or the power-control bit being set to 1. Either way, `periph_rst` rises in the same cycle as `pwr_en`, and `clk_en` stays 0.
- R6: Moving between the clocked state and the powered-but-unclocked state never raises `periph_rst`.
- R7: The power-control bit is bit 0 of `reg_rdata` and is loaded from `reg_wdata[0]` in any cycle where `reg_wr` is 1. Bits 31:1 of `reg_rdata` always read 0, and writes to them have no effect.
- R8: While `rst_n` is low, `pwr_en`=1, `clk_en`=1, `periph_rst`=0, and `reg_rdata`=32'h1.
- R9: The peripheral reset lasts exactly RST_LEN cycles (4 by default), with `clk_en` held at 0 throughout. In the next cycle the block enters the state that the current inputs call for.
- R10: If the inputs call for the fully off state while the reset pulse is running, the pulse stops and the block goes fully off. Power coming back later starts a new full pulse.
- R11: A change of mode or gating enable shows at the outputs after the first clock edge. A register write shows at the outputs after the second clock edge, and at `reg_rdata` after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Operating mode code (00 run, 01 sleep, 1x deep-sleep) |
| gate_run | input | 1 | Clock-gating enable used in run mode |
| gate_sleep | input | 1 | Clock-gating enable used in sleep mode |
| gate_deep | input | 1 | Clock-gating enable used in deep-sleep mode |
| reg_wr | input | 1 | Write strobe for the power-control register |
| reg_wdata | input | 32 | Write data for the power-control register |
| reg_rdata | output | 32 | Read-back of the power-control register |
| pwr_en | output | 1 | Peripheral power enable |
| clk_en | output | 1 | Peripheral clock enable |
| periph_rst | output | 1 | Peripheral reset pulse, active high |

## Verification
The assertions assume that mode, enables and write strobe are synchronous to the always-on clock and stable around its rising edge. They also assume RST_LEN is small enough that the pulse-length counter covers it. The stimulus changes every input only on the falling edge and holds it for whole cycles. A peripheral reset pulse is either allowed to run to its end or deliberately stopped by a move to the fully off state, so that the pulse-length check sees both outcomes. Mode code 2'b11 is driven only with the sleep enable set differently from the deep-sleep enable, so that a wrong pick would show at the outputs.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

   // Sequencer states of the gating controller
   typedef enum logic [1:0] {
      ST_ON   = 2'd0,   // powered and clocked
      ST_HOLD = 2'd1,   // powered, clock stopped, state kept
      ST_OFF  = 2'd2,   // unpowered, state lost
      ST_RST  = 2'd3    // powered, peripheral reset running
   } pcg_state_e;

   // Target condition requested by the current inputs
   typedef enum logic [1:0] {
      TGT_ON   = 2'd0,
      TGT_HOLD = 2'd1,
      TGT_OFF  = 2'd2
   } pcg_target_e;

   typedef struct packed {
      logic pwr;
      logic clk;
      logic rst;
   } pcg_out_t;

endpackage

// File: rtl/pcg_mode_sel.sv
module pcg_mode_sel #(
   parameter int NUM_MODES = 3,
   parameter int MODE_W    = 2
) (
   input  logic [MODE_W-1:0]    mode,
   input  logic [NUM_MODES-1:0] gate_vec,
   output logic                 sel_gate
);

   localparam int LAST_MODE = NUM_MODES - 1;

   generate
      if (NUM_MODES < 1) begin : g_bad_modes
         $error("pcg_mode_sel: NUM_MODES must be at least 1");
      end
      if ((1 << MODE_W) < NUM_MODES) begin : g_bad_width
         $error("pcg_mode_sel: MODE_W too narrow for NUM_MODES");
      end
   endgenerate

   logic [NUM_MODES-1:0] hit;

   // Codes beyond the last mode fold onto the last (deepest) mode
   generate
      for (genvar i = 0; i < NUM_MODES; i++) begin : g_dec
         if (i == LAST_MODE) begin : g_last
            assign hit[i] = (int'(mode) >= LAST_MODE);
         end else begin : g_mid
            assign hit[i] = (int'(mode) == i);
         end
      end
   endgenerate

   assign sel_gate = |(hit & gate_vec);

   // R1
   always_comb begin
      onehot_pick_chk: assert ($onehot(hit) || $isunknown(mode));
   end

endmodule

// File: rtl/pcg_ctrl_reg.sv
module pcg_ctrl_reg #(
   parameter int   DATA_W  = 32,
   parameter logic CTL_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              ctl_bit,
   output logic [DATA_W-1:0] rd_data
);

   localparam int PAD_W = DATA_W - 1;

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("pcg_ctrl_reg: DATA_W must be at least 1");
      end
   endgenerate

   logic ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RST;
      end else if (wr_en) begin
         ctl_q <= wr_data[0];
      end
   end

   assign ctl_bit = ctl_q;

   generate
      if (DATA_W > 1) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, ctl_q};
      end else begin : g_nopad
         assign rd_data = ctl_q;
      end
   endgenerate

   // R7
   wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ctl_bit == $past(wr_data[0])));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(ctl_bit));

endmodule

// File: rtl/pcg_seq.sv
module pcg_seq
   import pcg_pkg::*;
#(
   parameter int RST_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_gate,
   input  logic ctl_bit,
   output logic pwr_en,
   output logic clk_en,
   output logic periph_rst
);

   localparam int CNT_W            = (RST_LEN > 1) ? $clog2(RST_LEN) : 1;
   localparam int RUN_W            = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_LEN - 1);

   generate
      if (RST_LEN < 1) begin : g_bad_len
         $error("pcg_seq: RST_LEN must be at least 1");
      end
   endgenerate

   pcg_target_e tgt;
   pcg_state_e  state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic        lost_q, lost_d;
   pcg_out_t    out_q, out_d;

   // Requested condition from the picked enable and the control bit
   always_comb begin
      if (sel_gate)     tgt = TGT_ON;
      else if (ctl_bit) tgt = TGT_HOLD;
      else              tgt = TGT_OFF;
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      lost_d  = lost_q;
      unique case (state_q)
         ST_ON, ST_HOLD: begin
            unique case (tgt)
               TGT_ON:   state_d = ST_ON;
               TGT_HOLD: state_d = ST_HOLD;
               default: begin
                  state_d = ST_OFF;
                  lost_d  = 1'b1;
               end
            endcase
         end
         ST_OFF: begin
            if (tgt != TGT_OFF) begin
               state_d = ST_RST;
               cnt_d   = '0;
            end
         end
         ST_RST: begin
            if (tgt == TGT_OFF) begin
               state_d = ST_OFF;
            end else if (cnt_q == CNT_LAST) begin
               state_d = (tgt == TGT_ON) ? ST_ON : ST_HOLD;
               lost_d  = 1'b0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: state_d = ST_ON;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_ON:   out_d = '{pwr: 1'b1, clk: 1'b1, rst: 1'b0};
         ST_HOLD: out_d = '{pwr: 1'b1, clk: 1'b0, rst: 1'b0};
         ST_RST:  out_d = '{pwr: 1'b1, clk: 1'b0, rst: 1'b1};
         default: out_d = '{pwr: 1'b0, clk: 1'b0, rst: 1'b0};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ON;
         cnt_q   <= '0;
         lost_q  <= 1'b0;
         out_q   <= '{pwr: 1'b1, clk: 1'b1, rst: 1'b0};
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         lost_q  <= lost_d;
         out_q   <= out_d;
      end
   end

   assign pwr_en     = out_q.pwr;
   assign clk_en     = out_q.clk;
   assign periph_rst = out_q.rst;

   // Pulse-length tracker for the checks below
   logic [RUN_W-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= '0;
      else if (periph_rst) run_q <= run_q + 1'b1;
      else                 run_q <= '0;
   end

   // R4
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> (!clk_en && !periph_rst && lost_q));

   // R5
   pwr_return_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> (periph_rst && !clk_en));

   // R6
   no_spurious_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(periph_rst) |-> !$past(pwr_en));

   // R9
   rst_no_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst |-> (!clk_en && pwr_en));

   // R9
   rst_len_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst |-> (run_q < RUN_W'(RST_LEN)));

   // R9
   rst_len_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(periph_rst) && pwr_en) |-> (run_q == RUN_W'(RST_LEN)));

   // R10
   lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lost_q) |-> (pwr_en && !periph_rst));

endmodule

// File: rtl/pcg_ctrl.sv
module pcg_ctrl #(
   parameter int   DATA_W  = 32,
   parameter int   RST_LEN = 4,
   parameter logic CTL_RST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        mode,
   input  logic              gate_run,
   input  logic              gate_sleep,
   input  logic              gate_deep,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              pwr_en,
   output logic              clk_en,
   output logic              periph_rst
);

   localparam int NUM_MODES = 3;
   localparam int MODE_W    = 2;

   logic [NUM_MODES-1:0] gate_vec;
   logic                 sel_gate;
   logic                 ctl_bit;

   assign gate_vec = {gate_deep, gate_sleep, gate_run};

   pcg_mode_sel #(
      .NUM_MODES (NUM_MODES),
      .MODE_W    (MODE_W)
   ) i_mode_sel (
      .mode     (mode),
      .gate_vec (gate_vec),
      .sel_gate (sel_gate)
   );

   pcg_ctrl_reg #(
      .DATA_W  (DATA_W),
      .CTL_RST (CTL_RST)
   ) i_ctrl_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr),
      .wr_data (reg_wdata),
      .ctl_bit (ctl_bit),
      .rd_data (reg_rdata)
   );

   pcg_seq #(
      .RST_LEN (RST_LEN)
   ) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_gate   (sel_gate),
      .ctl_bit    (ctl_bit),
      .pwr_en     (pwr_en),
      .clk_en     (clk_en),
      .periph_rst (periph_rst)
   );

   // R7
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata >> 1) == '0);

   // R2
   gate_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_gate && pwr_en && !periph_rst) |=> (clk_en || periph_rst));

endmodule

// File: tb/test_pcg_ctrl.sv
module test_pcg_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  mode;
   logic        gate_run, gate_sleep, gate_deep;
   logic        reg_wr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        pwr_en, clk_en, periph_rst;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   typedef struct {
      logic        p;
      logic        c;
      logic        r;
      logic [31:0] rd;
      string       tag;
   } exp_t;

   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   pcg_ctrl i_pcg_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode),
      .gate_run   (gate_run),
      .gate_sleep (gate_sleep),
      .gate_deep  (gate_deep),
      .reg_wr     (reg_wr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .pwr_en     (pwr_en),
      .clk_en     (clk_en),
      .periph_rst (periph_rst)
   );

   task automatic compare(input exp_t e);
      n_chk++;
      if (pwr_en !== e.p || clk_en !== e.c || periph_rst !== e.r || reg_rdata !== e.rd) begin
         n_fail++;
         $display("FAIL %s: pwr/clk/rst=%b%b%b rd=%h, expected %b%b%b rd=%h",
                  e.tag, pwr_en, clk_en, periph_rst, reg_rdata, e.p, e.c, e.r, e.rd);
      end
   endtask

   // Driver: applies one cycle of inputs and queues the outputs due after the next edge
   task automatic step(input logic [1:0] m, input logic gr, input logic gs, input logic gd,
                       input logic we, input logic [31:0] wd,
                       input logic ep, input logic ec, input logic er,
                       input logic [31:0] erd, input string tag);
      exp_t e;
      @(negedge clk);
      mode       = m;
      gate_run   = gr;
      gate_sleep = gs;
      gate_deep  = gd;
      reg_wr     = we;
      reg_wdata  = wd;
      e.p = ep; e.c = ec; e.r = er; e.rd = erd; e.tag = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: compares each queued item just after the edge it belongs to
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb_q.size() != 0) compare(sb_q.pop_front());
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      exp_t r8;
      rst_n = 1'b0; mode = 2'b00;
      gate_run = 1'b1; gate_sleep = 1'b1; gate_deep = 1'b1;
      reg_wr = 1'b0; reg_wdata = '0;
      repeat (3) @(posedge clk);
      #1;
      r8.p = 1; r8.c = 1; r8.r = 0; r8.rd = 32'h1; r8.tag = "R8 reset state";
      compare(r8);
      @(negedge clk);
      rst_n = 1'b1;

      //    mode  gr gs gd we  wdata          p  c  r  rd
      step(2'd0, 0, 1, 1, 0, 32'h0,          1, 0, 0, 32'h1, "R3 hold state");
      step(2'd0, 0, 1, 1, 0, 32'h0,          1, 0, 0, 32'h1, "R3 hold steady");
      step(2'd0, 1, 1, 1, 0, 32'h0,          1, 1, 0, 32'h1, "R6 hold to on, no reset");
      step(2'd0, 1, 1, 1, 1, 32'hFFFF_FFFF,  1, 1, 0, 32'h1, "R7 reserved bits read 0");
      step(2'd0, 1, 1, 1, 1, 32'h0,          1, 1, 0, 32'h0, "R7 clear control bit");
      step(2'd0, 1, 1, 1, 0, 32'h0,          1, 1, 0, 32'h0, "R2 enable overrides control");
      step(2'd0, 0, 1, 1, 0, 32'h0,          0, 0, 0, 32'h0, "R4 fully off");
      step(2'd0, 0, 1, 1, 0, 32'h0,          0, 0, 0, 32'h0, "R4 stays off");
      step(2'd1, 0, 1, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R5 mode change restores power");
      step(2'd1, 0, 1, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R9 pulse cycle 2");
      step(2'd1, 0, 1, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R9 pulse cycle 3");
      step(2'd1, 0, 1, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R9 pulse cycle 4");
      step(2'd1, 0, 1, 1, 0, 32'h0,          1, 1, 0, 32'h0, "R9 pulse ends, clocked");
      step(2'd2, 0, 1, 0, 0, 32'h0,          0, 0, 0, 32'h0, "R1 deep mode picks deep enable");
      step(2'd2, 0, 1, 0, 1, 32'h1,          0, 0, 0, 32'h1, "R11 write not yet at outputs");
      step(2'd2, 0, 1, 0, 0, 32'h0,          1, 0, 1, 32'h1, "R5 control write restores power");
      step(2'd2, 0, 1, 0, 0, 32'h0,          1, 0, 1, 32'h1, "R9 pulse cycle 2");
      step(2'd2, 0, 1, 0, 0, 32'h0,          1, 0, 1, 32'h1, "R9 pulse cycle 3");
      step(2'd2, 0, 1, 0, 0, 32'h0,          1, 0, 1, 32'h1, "R9 pulse cycle 4");
      step(2'd2, 0, 1, 0, 0, 32'h0,          1, 0, 0, 32'h1, "R3 pulse ends in hold");
      step(2'd2, 0, 1, 0, 1, 32'h0,          1, 0, 0, 32'h0, "R11 write not yet at outputs");
      step(2'd2, 0, 1, 0, 0, 32'h0,          0, 0, 0, 32'h0, "R4 off again");
      step(2'd2, 0, 1, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R5 enable restores power");
      step(2'd2, 0, 1, 0, 0, 32'h0,          0, 0, 0, 32'h0, "R10 pulse aborted to off");
      step(2'd3, 0, 0, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R1 code 3 picks deep enable");
      step(2'd3, 0, 0, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R10 fresh pulse cycle 2");
      step(2'd3, 0, 0, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R10 fresh pulse cycle 3");
      step(2'd3, 0, 0, 1, 0, 32'h0,          1, 0, 1, 32'h0, "R10 fresh pulse cycle 4");
      step(2'd3, 0, 0, 1, 0, 32'h0,          1, 1, 0, 32'h0, "R2 clocked after pulse");
      step(2'd1, 1, 0, 1, 0, 32'h0,          0, 0, 0, 32'h0, "R1 sleep ignores other enables");
      step(2'd0, 0, 1, 1, 0, 32'h0,          0, 0, 0, 32'h0, "R1 run ignores other enables");

      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule